// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block sits between a core's load/store port and a 16-bit memory bus. The core issues byte or word reads and writes at any byte address. A word that starts on an even address, and any byte, goes out as one bus cycle. A word that starts on an odd address goes out as two byte-wide bus cycles. The block joins the two halves, so the core always receives one completion that carries the whole word. The only sign of a split is the longer wait.

Memory sees a word address, two byte-lane enables and a write-enable, all held for a fixed number of clocks per bus cycle. Write bytes are moved onto the lanes that match their target addresses. Read bytes are taken from the enabled lanes and placed in their proper positions in the returned word. Wait states, refresh and caching belong to other blocks. The core must wait for the completion of one request before it issues the next.

Top module: `misaligned_splitter`

## Requirements
- R1: While reset is held and on the first clock after it, `req_ready` is 1, `mem_cyc` is 0 and `resp_valid` is 0.
- R2: A word request at an even byte address A produces one bus cycle. Its word address is A>>1 and `mem_be` is 2'b11.
- R3: A word request at an odd byte address A produces two bus cycles. The first has word address A>>1 with `mem_be`=2'b10 (upper lane). The second has word address (A>>1)+1 with `mem_be`=2'b01 (lower lane). The second address wraps to 0 at the top of the address space.
- R4: A byte request at byte address A produces one bus cycle at word address A>>1. `mem_be` is 2'b01 when A is even and 2'b10 when A is odd.
- R5: On writes, `mem_we` is 1 and each enabled lane carries its target byte. For a byte write, `req_wdata[7:0]` goes on the addressed lane. For an aligned word, lane 0 gets `req_wdata[7:0]` and lane 1 gets `req_wdata[15:8]`. For a split word, the first cycle's lane 1 gets `req_wdata[7:0]` and the second cycle's lane 0 gets `req_wdata[15:8]`. A lane that is not enabled carries zero.
- R6: On reads, `resp_rdata` holds the byte at A in bits [7:0]. For a word it also holds the byte at A+1 in bits [15:8]. For a byte, bits [15:8] are zero.
- R7: Every bus cycle lasts exactly CYCLE_CLKS clocks. `resp_valid` is a single-clock pulse on the clock after the last bus clock, so completion comes CYCLE_CLKS+1 clocks after acceptance (2*CYCLE_CLKS+1 when split). Each request gets exactly one completion.
- R8: `req_ready` is 0 from the clock after acceptance until the completion clock. While it is 0, `req_valid` and the request fields have no effect on the bus or on the result.
- R9: Within a bus cycle, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` stay constant on every clock.
- R10: During a read bus cycle, `mem_we` is 0 and `mem_wdata` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data, low byte in [7:0] |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_rdata | output | 16 | Read result, valid with resp_valid |
| mem_cyc | output | 1 | Bus cycle in progress |
| mem_addr | output | ADDR_W-1 | Word address on the bus |
| mem_be | output | 2 | Byte lane enables, bit 0 = low lane |
| mem_we | output | 1 | Bus write strobe |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The bench builds the block with ADDR_W=8 and CYCLE_CLKS=3. The narrow address makes the byte space only 256 entries. Random addresses therefore often land on the last byte, where the second half of a split word must wrap to word 0, and random traffic often reads back locations that earlier random writes touched. A cycle length of 3 keeps aligned and split latencies short while leaving middle clocks in each bus cycle where stability can be checked.

// File: rtl/msplit_pkg.sv
// Shared constants and types for the misaligned word access splitter.
// Assumes a 16-bit data bus made of two 8-bit byte lanes.
package msplit_pkg;
    localparam int BUS_W  = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = BUS_W / LANE_W;

    // Which bus cycle of a request is in progress.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    // Request attributes held for the whole access.
    typedef struct packed {
        logic             we;
        logic             wide;
        logic [BUS_W-1:0] wdata;
    } req_attr_t;
endpackage

// File: rtl/msplit_lane_plan.sv
// Turns a held request and the current phase into bus controls: the word
// address, the lane enables and the lane-steered write data. It also flags
// whether the request needs two bus cycles.
// Assumes: the address is a byte address, and for a split word the phase
// input is 0 during the low-byte cycle and 1 during the high-byte cycle.
module msplit_lane_plan
    import msplit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  req_attr_t          attr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               second,
    output logic               split,
    output logic [ADDR_W-2:0]  word_addr,
    output logic [LANES-1:0]   lane_en,
    output logic [BUS_W-1:0]   lane_wdata
);
    localparam int WA_W = ADDR_W - 1;

    logic odd;
    assign odd = addr[0];

    // A word that starts on an odd byte needs two cycles.
    assign split = attr.wide & odd;

    // Second cycle of a split goes to the next word; the add wraps at the top.
    assign word_addr = addr[ADDR_W-1:1] + WA_W'(second);

    // Lane enable choice by access kind and phase.
    always_comb begin
        if (!attr.wide) begin
            lane_en = odd ? 2'b10 : 2'b01;
        end else if (!odd) begin
            lane_en = 2'b11;
        end else if (!second) begin
            lane_en = 2'b10;
        end else begin
            lane_en = 2'b01;
        end
    end

    // Write steering, one byte lane per generate step.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] src;

        // Pick the source byte that belongs on lane l.
        always_comb begin
            if (!attr.wide) begin
                src = attr.wdata[LANE_W-1:0];
            end else if (!odd) begin
                src = attr.wdata[l*LANE_W +: LANE_W];
            end else begin
                src = attr.wdata[(LANES-1-l)*LANE_W +: LANE_W];
            end
        end

        assign lane_wdata[l*LANE_W +: LANE_W] =
            (attr.we && lane_en[l]) ? src : '0;
    end
endmodule

// File: rtl/msplit_beat_timer.sv
// Counts the clocks of one bus cycle and flags its final clock.
// Assumes run stays high across back-to-back bus cycles. The count
// restarts on the final clock, so the next cycle starts at once.
module msplit_beat_timer #(
    parameter int CYCLE_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CYCLE_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == CNT_END);

    // Advance while a bus cycle runs; clear when idle or at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/msplit_read_merge.sv
// Builds the word returned to the requester from the bus read data. A byte
// is shifted down from its lane. An aligned word passes through. A split
// word joins the low byte held from the first cycle with the lower lane of
// the second cycle.
// Assumes capture_lo pulses on the final clock of a split's first cycle.
module msplit_read_merge
    import msplit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_lo,
    input  logic             wide,
    input  logic             odd,
    input  logic [BUS_W-1:0] rdata,
    output logic [BUS_W-1:0] merged
);
    logic [LANE_W-1:0] lo_q;

    // Hold the upper lane of the first cycle of a split read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (capture_lo) begin
            lo_q <= rdata[BUS_W-1 -: LANE_W];
        end
    end

    // Put the selected bytes in their places in the returned word.
    always_comb begin
        if (!wide) begin
            merged = {{LANE_W{1'b0}},
                      odd ? rdata[BUS_W-1 -: LANE_W] : rdata[LANE_W-1:0]};
        end else if (!odd) begin
            merged = rdata;
        end else begin
            merged = {rdata[LANE_W-1:0], lo_q};
        end
    end
endmodule

// File: rtl/misaligned_splitter.sv
// Bus interface between a core data port and a 16-bit memory bus. It takes
// one byte/word request at a time, runs one or two fixed-length bus cycles,
// and returns a single completion.
// Assumes memory returns read data by the final clock of each bus cycle and
// takes write data on that clock; memory wait states are not modelled here.
module misaligned_splitter
    import msplit_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CYCLE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              resp_valid,
    output logic [15:0]       resp_rdata,
    output logic              mem_cyc,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    phase_e              phase_q;
    req_attr_t           attr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                split;
    logic                last;
    logic                busy;
    logic [ADDR_W-2:0]   plan_addr;
    logic [LANES-1:0]    plan_en;
    logic [BUS_W-1:0]    plan_wdata;
    logic [BUS_W-1:0]    merged;

    assign busy      = (phase_q != PH_IDLE);
    assign req_ready = !busy;

    // Bus controls come straight from the held request and the phase.
    msplit_lane_plan #(.ADDR_W(ADDR_W)) u_plan (
        .attr       (attr_q),
        .addr       (addr_q),
        .second     (phase_q == PH_SECOND),
        .split      (split),
        .word_addr  (plan_addr),
        .lane_en    (plan_en),
        .lane_wdata (plan_wdata)
    );

    msplit_beat_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .last  (last)
    );

    msplit_read_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_lo (last && (phase_q == PH_FIRST) && split),
        .wide       (attr_q.wide),
        .odd        (addr_q[0]),
        .rdata      (mem_rdata),
        .merged     (merged)
    );

    assign mem_cyc   = busy;
    assign mem_addr  = busy ? plan_addr : '0;
    assign mem_be    = busy ? plan_en : '0;
    assign mem_we    = busy && attr_q.we;
    assign mem_wdata = busy ? plan_wdata : '0;

    // Phase sequencing, request capture and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            attr_q     <= '0;
            addr_q     <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        attr_q  <= '{we: req_we, wide: req_wide, wdata: req_wdata};
                        addr_q  <= req_addr;
                        phase_q <= PH_FIRST;
                    end
                end
                PH_FIRST: begin
                    if (last) begin
                        if (split) begin
                            phase_q <= PH_SECOND;
                        end else begin
                            phase_q    <= PH_IDLE;
                            resp_valid <= 1'b1;
                            resp_rdata <= attr_q.we ? '0 : merged;
                        end
                    end
                end
                PH_SECOND: begin
                    if (last) begin
                        phase_q    <= PH_IDLE;
                        resp_valid <= 1'b1;
                        resp_rdata <= attr_q.we ? '0 : merged;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msplit_checker.sv
// Protocol checks on the splitter ports, attached with bind below.
// Assumes the same parameters as the instance it is bound to.
module msplit_checker #(
    parameter int ADDR_W     = 16,
    parameter int CYCLE_CLKS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_cyc,
    input logic [ADDR_W-2:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic              mem_we,
    input logic [15:0]       mem_wdata
);
    int unsigned beat_cnt;
    int unsigned bus_clks;

    // Position within the current bus cycle, counted from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= 0;
        end else if (mem_cyc) begin
            beat_cnt <= (beat_cnt == CYCLE_CLKS - 1) ? 0 : beat_cnt + 1;
        end else begin
            beat_cnt <= 0;
        end
    end

    // Bus clocks spent since the previous completion.
    always_ff @(posedge clk) begin
        if (!rst_n || resp_valid) begin
            bus_clks <= 0;
        end else if (mem_cyc) begin
            bus_clks <= bus_clks + 1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_cyc && !resp_valid));

    assert_lane_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> (mem_be != 2'b00));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> !req_ready);

    assert_resp_follows_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(mem_cyc) && !mem_cyc));

    assert_resp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_resp_bus_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (bus_clks == CYCLE_CLKS || bus_clks == 2 * CYCLE_CLKS));

    assert_cycle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cyc && beat_cnt != 0) |->
            ($stable(mem_addr) && $stable(mem_be) && $stable(mem_we) && $stable(mem_wdata)));

    assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cyc && !mem_we) |-> (mem_wdata == 16'h0000));
endmodule

bind misaligned_splitter msplit_checker #(
    .ADDR_W     (ADDR_W),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_cyc    (mem_cyc),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
);

// File: tb/misaligned_splitter_bench.sv
module misaligned_splitter_bench;
    localparam int AW   = 8;
    localparam int CYC  = 3;
    localparam int NW   = 1 << (AW - 1);
    localparam int NB   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic          req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          resp_valid;
    logic [15:0]   resp_rdata;
    logic          mem_cyc;
    logic [AW-2:0] mem_addr;
    logic [1:0]    mem_be;
    logic          mem_we;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;

    logic [15:0] bmem [NW];
    logic [7:0]  refb [NB];
    int          bcnt = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    misaligned_splitter #(.ADDR_W(AW), .CYCLE_CLKS(CYC)) u_misaligned_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_cyc(mem_cyc), .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h0105) ^ 16'hA35C;
    endfunction

    // Bus memory model: combinational read, write on the last clock of a cycle.
    assign mem_rdata = mem_cyc ? bmem[mem_addr] : 16'hDEAD;

    always @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= 0;
            for (int i = 0; i < NW; i++) bmem[i] <= init_word(i);
        end else if (mem_cyc) begin
            if (bcnt == CYC - 1) begin
                bcnt <= 0;
                if (mem_we) begin
                    if (mem_be[0]) bmem[mem_addr][7:0]  <= mem_wdata[7:0];
                    if (mem_be[1]) bmem[mem_addr][15:8] <= mem_wdata[15:8];
                end
            end else begin
                bcnt <= bcnt + 1;
            end
        end else begin
            bcnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One request: compute expectations, drive, observe the bus, compare.
    task automatic run_req(input bit we, input bit wd, input logic [AW-1:0] a,
                           input logic [15:0] d, input bit noisy);
        int nph;
        logic [AW-2:0] ea [2];
        logic [1:0]    eb [2];
        logic [15:0]   ew [2];
        logic [AW-2:0] ga [2];
        logic [1:0]    gb [2];
        logic [15:0]   gw [2];
        logic          gwe [2];
        logic [AW-1:0] a1;
        logic [15:0]   erd;
        string         tag;
        int lat, cc, unstable, busy_bad;

        a1  = a + 1'b1;
        nph = (wd && a[0]) ? 2 : 1;
        tag = !wd ? "R4" : (a[0] ? "R3" : "R2");
        ea[0] = a[AW-1:1];
        ea[1] = a[AW-1:1] + 1'b1;
        eb[1] = 2'b00;
        ew[1] = 16'h0;
        if (!wd) eb[0] = a[0] ? 2'b10 : 2'b01;
        else if (!a[0]) eb[0] = 2'b11;
        else begin eb[0] = 2'b10; eb[1] = 2'b01; end
        if (!we) begin
            ew[0] = 16'h0;
        end else if (!wd) begin
            ew[0] = a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
        end else if (!a[0]) begin
            ew[0] = d;
        end else begin
            ew[0] = {d[7:0], 8'h00};
            ew[1] = {8'h00, d[15:8]};
        end
        erd = wd ? {refb[a1], refb[a]} : {8'h00, refb[a]};

        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_we = we; req_wide = wd; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        if (noisy) begin
            req_valid = 1'b1; req_we = 1'($urandom); req_wide = 1'($urandom);
            req_addr = AW'($urandom); req_wdata = 16'($urandom);
        end else begin
            req_valid = 1'b0;
        end
        lat = 1; cc = 0; unstable = 0; busy_bad = 0;
        for (int k = 0; k < 2; k++) begin ga[k] = '0; gb[k] = '0; gw[k] = '0; gwe[k] = 1'b0; end
        while (!resp_valid && lat < 60) begin
            if (mem_cyc) begin
                if (cc % CYC == 0) begin
                    if (cc / CYC < 2) begin
                        ga[cc/CYC] = mem_addr; gb[cc/CYC] = mem_be;
                        gw[cc/CYC] = mem_wdata; gwe[cc/CYC] = mem_we;
                    end
                end else if (cc / CYC < 2) begin
                    if (mem_addr != ga[cc/CYC] || mem_be != gb[cc/CYC] ||
                        mem_wdata != gw[cc/CYC] || mem_we != gwe[cc/CYC]) unstable++;
                end
                cc++;
            end
            if (req_ready && !resp_valid) busy_bad++;
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;

        chk(resp_valid == 1'b1, "R7", "completion seen", 32'(resp_valid), 1);
        chk(lat == nph * CYC + 1, "R7", "completion latency", 32'(lat), 32'(nph * CYC + 1));
        chk(cc == nph * CYC, tag, "bus clocks", 32'(cc), 32'(nph * CYC));
        for (int p = 0; p < nph; p++) begin
            chk(ga[p] == ea[p], tag, "word address", 32'(ga[p]), 32'(ea[p]));
            chk(gb[p] == eb[p], tag, "lane enables", 32'(gb[p]), 32'(eb[p]));
            chk(gw[p] == ew[p], we ? "R5" : "R10", "bus write data", 32'(gw[p]), 32'(ew[p]));
            chk(gwe[p] == we, we ? "R5" : "R10", "bus write strobe", 32'(gwe[p]), 32'(we));
        end
        chk(unstable == 0, "R9", "bus held within cycle", 32'(unstable), 0);
        chk(busy_bad == 0, "R8", "ready low while busy", 32'(busy_bad), 0);
        if (!we) chk(resp_rdata == erd, "R6", "read data", 32'(resp_rdata), 32'(erd));

        @(negedge clk);
        chk(resp_valid == 1'b0, "R7", "completion is one pulse", 32'(resp_valid), 0);
        chk(!mem_cyc && req_ready, "R8", "no bus activity from busy-time request",
            {30'h0, mem_cyc, req_ready}, 32'h1);

        if (we) begin
            refb[a] = d[7:0];
            if (wd) refb[a1] = d[15:8];
        end
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NW; i++) begin
            refb[2*i]   = init_word(i)[7:0];
            refb[2*i+1] = init_word(i)[15:8];
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_cyc && !resp_valid, "R1", "idle during reset",
            {29'h0, req_ready, mem_cyc, resp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_cyc && !resp_valid, "R1", "idle after reset",
            {29'h0, req_ready, mem_cyc, resp_valid}, 32'h4);

        // Directed corners
        run_req(1'b0, 1'b1, 8'h10, 16'h0, 1'b0);   // R2 aligned read
        run_req(1'b1, 1'b1, 8'h10, 16'hBEEF, 1'b0); // R2 aligned write
        run_req(1'b0, 1'b1, 8'h10, 16'h0, 1'b0);
        run_req(1'b1, 1'b1, 8'h21, 16'h1234, 1'b0); // R3 split write
        run_req(1'b0, 1'b1, 8'h21, 16'h0, 1'b0);    // R3 split read back
        run_req(1'b0, 1'b0, 8'h21, 16'h0, 1'b0);    // R4 odd byte
        run_req(1'b0, 1'b0, 8'h22, 16'h0, 1'b0);    // R4 even byte
        run_req(1'b1, 1'b1, 8'hFF, 16'hC0DE, 1'b0); // R3 wrap at top
        run_req(1'b0, 1'b1, 8'hFF, 16'h0, 1'b0);
        run_req(1'b0, 1'b1, 8'h00, 16'h0, 1'b0);
        run_req(1'b1, 1'b0, 8'h33, 16'hAB77, 1'b1); // R5 odd byte write, noisy
        run_req(1'b0, 1'b1, 8'h32, 16'h0, 1'b1);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            run_req(1'($urandom), 1'($urandom), AW'($urandom), 16'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule